// File: doc/BRIEF.md
# Guarded Mantissa Rounding Unit

This block takes a fraction mantissa that carries G extra low-order guard bits beyond its N kept bits, and reduces it to N bits under one of three selectable policies. The policies are plain truncation, jamming, and round-to-nearest with ties to even. If rounding pushes the kept bits past all ones, the block renormalizes the result to 0.100…0 and adds one to the exponent code. If that exponent code was already at its largest value, the block raises an overflow flag and saturates instead.

It sits after the add, multiply or divide datapath of a floating-point unit, once alignment and the first normalization are done. The rounding logic is purely combinational. A parameter selects a single output register stage, which is the default, with a valid bit that travels alongside the data.

N, G and the exponent width E are parameters. The default configuration is N=6 and G=6, which allows short worked examples to be checked by hand.

Top module: `rnd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registers clear: `out_valid`, `out_mant`, `out_exp` and `out_ovf` read 0 after that edge.
- R2: Mode 2'b00 (chop) outputs the upper N bits of `in_mant` unchanged, passes `in_exp` through and keeps `out_ovf` at 0. The result is never larger than the guarded input.
- R3: Mode 2'b11 behaves exactly like mode 2'b00.
- R4: Mode 2'b01 (jam) outputs the upper N bits with bit 0 forced to 1 whenever any of the G low guard bits is 1. When all guard bits are 0, it outputs the upper N bits unchanged. For example, 011010|001000 gives 011011, and 011011|001000 gives 011011.
- R5: In mode 2'b10 (nearest), guard bits below one half of an LSB are dropped. Guard bits above one half add 1 to the kept bits. The guard MSB (bit G-1 of `in_mant`) weighs one half.
- R6: In mode 2'b10, an exact half rounds to the even neighbour. An exact half means the guard MSB is 1 and all lower guard bits are 0. The kept bits stay unchanged when their LSB is 0 and are incremented when their LSB is 1.
- R7: When the increment carries out of N bits, `out_mant` is 1 followed by N-1 zeros and `out_exp` is `in_exp`+1. For example, 111111|100000 in nearest mode gives 100000.
- R8: When a carry-out occurs with `in_exp` all ones, `out_ovf` is 1, `out_mant` is all ones and `out_exp` stays all ones. In every other case `out_ovf` is 0.
- R9: With the output register enabled, each result appears one clock after its input, and `out_valid` equals `in_valid` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_mant | input | N+G | Guarded mantissa, binary point left of the MSB |
| in_exp | input | E | Exponent code |
| in_mode | input | 2 | Rounding policy select |
| out_valid | output | 1 | Result qualifier |
| out_mant | output | N | Rounded mantissa |
| out_exp | output | E | Adjusted exponent code |
| out_ovf | output | 1 | Exponent overflow on renormalization |

## Verification
A wrong tie decision or a lost sticky bit shows up as a single-LSB error in `out_mant`. It appears on the very next clock after the offending input, so each mismatch points to exactly one input. A broken carry path shows as an unchanged exponent, or as an all-zero mantissa, on the same cycle. The bench therefore drives the hand-worked tie, carry and saturation cases, followed by a large spread of random guarded values in every mode. It compares each result with an arithmetic model that works on whole integers rather than on bit fields.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_CHOP = 2'b00,
    RM_JAM  = 2'b01,
    RM_NEAR = 2'b10,
    RM_RSVD = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/rnd_guard_scan.sv
// Summarizes the guard field: half-LSB bit, sticky of the bits below it.
module rnd_guard_scan #(
  parameter int G = 6
) (
  input  logic [G-1:0] guard,
  output logic         half,
  output logic         tail_any,
  output logic         any_set
);
  assign half = guard[G-1];
  generate
    if (G > 1) begin : g_tail
      assign tail_any = |guard[G-2:0];
    end else begin : g_notail
      assign tail_any = 1'b0;
    end
  endgenerate
  assign any_set = half | tail_any;
endmodule

// File: rtl/rnd_decide.sv
// Chooses increment or jam per policy.
module rnd_decide
  import rnd_pkg::*;
(
  input  rnd_mode_e mode,
  input  logic      keep_lsb,
  input  logic      half,
  input  logic      tail_any,
  input  logic      any_set,
  output logic      inc,
  output logic      jam
);
  always_comb begin
    inc = 1'b0;
    jam = 1'b0;
    unique case (mode)
      RM_JAM:  jam = any_set;
      RM_NEAR: inc = half & (tail_any | keep_lsb);
      default: begin
        inc = 1'b0;
        jam = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rnd_renorm.sv
// Applies jam/increment, renormalizes on carry-out, saturates at exponent top.
module rnd_renorm #(
  parameter int N = 6,
  parameter int E = 8
) (
  input  logic [N-1:0] keep,
  input  logic         inc,
  input  logic         jam,
  input  logic [E-1:0] exp_in,
  output logic [N-1:0] mant,
  output logic [E-1:0] exp_out,
  output logic         ovf
);
  localparam logic [E-1:0] EXP_TOP = {E{1'b1}};
  localparam logic [N-1:0] MANT_HALF = {1'b1, {(N-1){1'b0}}};

  logic [N:0] sum;
  logic       carry;

  assign sum   = {1'b0, keep[N-1:1], keep[0] | jam} + {{N{1'b0}}, inc};
  assign carry = sum[N];

  always_comb begin
    mant    = sum[N-1:0];
    exp_out = exp_in;
    ovf     = 1'b0;
    if (carry) begin
      if (exp_in == EXP_TOP) begin
        mant    = {N{1'b1}};
        exp_out = EXP_TOP;
        ovf     = 1'b1;
      end else begin
        mant    = MANT_HALF;
        exp_out = exp_in + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int N       = 6,
  parameter int G       = 6,
  parameter int E       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N+G-1:0]   in_mant,
  input  logic [E-1:0]     in_exp,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  output logic [N-1:0]     out_mant,
  output logic [E-1:0]     out_exp,
  output logic             out_ovf
);
  localparam int W = N + G;

  logic [N-1:0] keep;
  logic [G-1:0] guard;
  logic         half, tail_any, any_set, inc, jam;
  logic [N-1:0] c_mant;
  logic [E-1:0] c_exp;
  logic         c_ovf;

  assign keep  = in_mant[W-1:G];
  assign guard = in_mant[G-1:0];

  rnd_guard_scan #(.G(G)) u_scan (
    .guard(guard), .half(half), .tail_any(tail_any), .any_set(any_set)
  );

  rnd_decide u_dec (
    .mode(rnd_mode_e'(in_mode)), .keep_lsb(keep[0]), .half(half),
    .tail_any(tail_any), .any_set(any_set), .inc(inc), .jam(jam)
  );

  rnd_renorm #(.N(N), .E(E)) u_norm (
    .keep(keep), .inc(inc), .jam(jam), .exp_in(in_exp),
    .mant(c_mant), .exp_out(c_exp), .ovf(c_ovf)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_mant  <= '0;
          out_exp   <= '0;
          out_ovf   <= 1'b0;
        end else begin
          out_valid <= in_valid;
          out_mant  <= c_mant;
          out_exp   <= c_exp;
          out_ovf   <= c_ovf;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_mant  = c_mant;
      assign out_exp   = c_exp;
      assign out_ovf   = c_ovf;
    end
  endgenerate
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int N       = 6,
  parameter int G       = 6,
  parameter int E       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N+G-1:0] in_mant,
  input logic [E-1:0]   in_exp,
  input logic [1:0]     in_mode,
  input logic           out_valid,
  input logic [N-1:0]   out_mant,
  input logic [E-1:0]   out_exp,
  input logic           out_ovf
);
  localparam int W = N + G;
  generate
    if (REG_OUT) begin : g_chk
      a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_ovf && out_mant == '0));

      a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

      a_r2_chop_exact: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_mode) == 2'b00 || $past(in_mode) == 2'b11)) |->
        (out_mant == $past(in_mant[W-1:G]) && out_exp == $past(in_exp) && !out_ovf));

      a_r4_jam_lsb: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_mode) == 2'b01 && $past(|in_mant[G-1:0])) |-> out_mant[0]);

      a_r7_renorm_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ovf && out_exp != $past(in_exp)) |->
        (out_mant == {1'b1, {(N-1){1'b0}}} && out_exp == $past(in_exp) + 1'b1));

      a_r8_ovf_sat: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf) |-> (&out_mant && &out_exp && &$past(in_exp)));
    end
  endgenerate
endmodule

bind rnd_unit rnd_unit_chk #(.N(N), .G(G), .E(E), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_mant(in_mant),
  .in_exp(in_exp), .in_mode(in_mode), .out_valid(out_valid),
  .out_mant(out_mant), .out_exp(out_exp), .out_ovf(out_ovf)
);

// File: tb/rnd_unit_test.sv
module rnd_unit_test;
  localparam int N = 6;
  localparam int G = 6;
  localparam int E = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N+G-1:0] in_mant = '0;
  logic [E-1:0] in_exp = '0;
  logic [1:0] in_mode = 2'b00;
  logic out_valid;
  logic [N-1:0] out_mant;
  logic [E-1:0] out_exp;
  logic out_ovf;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    longint mant;
    longint expo;
    bit     ovf;
    string  tag;
  } exp_item_t;
  exp_item_t sb[$];

  always #2.5 clk = ~clk;

  rnd_unit #(.N(N), .G(G), .E(E)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mant(in_mant),
    .in_exp(in_exp), .in_mode(in_mode), .out_valid(out_valid),
    .out_mant(out_mant), .out_exp(out_exp), .out_ovf(out_ovf)
  );

  function automatic exp_item_t model(longint m, longint e, int mode, string tag);
    exp_item_t it;
    longint k, rem, halfv, emax;
    k     = m / (64'd1 << G);
    rem   = m % (64'd1 << G);
    halfv = 64'd1 << (G - 1);
    emax  = (64'd1 << E) - 1;
    if (mode == 1) begin
      if (rem != 0 && (k % 2) == 0) k = k + 1;
    end else if (mode == 2) begin
      if (rem > halfv || (rem == halfv && (k % 2) == 1)) k = k + 1;
    end
    it.ovf = 1'b0;
    it.expo = e;
    it.tag = tag;
    if (k == (64'd1 << N)) begin
      if (e == emax) begin
        it.ovf = 1'b1;
        k = (64'd1 << N) - 1;
      end else begin
        k = 64'd1 << (N - 1);
        it.expo = e + 1;
      end
    end
    it.mant = k;
    return it;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic drive(longint m, longint e, int mode, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_mant  = m[N+G-1:0];
    in_exp   = e[E-1:0];
    in_mode  = mode[1:0];
    sb.push_back(model(m, e, mode, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares each result against the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected out_valid", 1, 0);
        end else begin
          exp_item_t it;
          it = sb.pop_front();
          check(out_mant == it.mant[N-1:0] && out_exp == it.expo[E-1:0] &&
                out_ovf == it.ovf, it.tag, "mant/exp/ovf",
                {out_ovf, out_exp, out_mant}, {it.ovf, it.expo[E-1:0], it.mant[N-1:0]});
        end
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && out_mant == 0 && out_exp == 0 && !out_ovf, "R1",
          "reset state", {out_valid, out_ovf, out_exp, out_mant}, 0);
    @(negedge clk);
    rst = 1'b0;

    // Directed corner cases (binary, kept|guard)
    drive(12'b011010_001000, 10, 1, "R4");  // -> 011011
    drive(12'b011011_001000, 10, 1, "R4");  // -> 011011
    drive(12'b011010_000000, 10, 1, "R4");  // -> 011010
    drive(12'b111111_111111, 20, 0, "R2");  // -> 111111
    drive(12'b101010_110011, 20, 3, "R3");  // -> 101010
    drive(12'b101010_011111, 30, 2, "R5");  // below half -> 101010
    drive(12'b101010_100001, 30, 2, "R5");  // above half -> 101011
    drive(12'b110100_100000, 30, 2, "R6");  // tie even -> 110100
    drive(12'b110101_100000, 30, 2, "R6");  // tie odd  -> 110110
    drive(12'b111111_100000, 40, 2, "R7");  // carry -> 100000, exp 41
    drive(12'b111111_100000, 255, 2, "R8"); // overflow saturate
    drive(12'b111111_111111, 255, 1, "R8"); // jam never carries
    drive(12'b111111_011111, 255, 2, "R8"); // no carry, no ovf
    idle();
    @(negedge clk);
    #1;
    check(!out_valid, "R9", "valid after idle", out_valid, 0);

    // Random sweep in every mode
    for (int i = 0; i < 4000; i++) begin
      int md;
      longint ev;
      md = i % 4;
      ev = (i % 7 == 0) ? 255 : longint'($urandom_range(0, 255));
      if (i % 5 == 0)
        drive({$urandom_range(0, 63), 1'b1, 5'($urandom_range(0, 1) ? 0 : 31)} & 12'hFFF,
              ev, md, md == 2 ? "R6" : "R5");
      else
        drive(longint'($urandom_range(0, 4095)), ev, md,
              md == 0 ? "R2" : (md == 3 ? "R3" : (md == 1 ? "R4" : "R5")));
    end
    idle();
    repeat (3) @(negedge clk);
    #1;
    check(sb.size() == 0, "R9", "results outstanding", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule